// File: doc/BRIEF.md
# Reference Track-and-Hold Mode Controller

This block is the operating-mode state machine of a clock card that steers a local oscillator towards one incoming DS1/E1 timing reference. It watches the line alarm flags of that reference, an oscillator warmup flag and a one-second tick. From these it decides whether the card runs free, acquires, tracks or holds. It also collects the signed phase-error samples that arrive on a strobe and produces one averaged phase value per second for the control law. A second's samples are delivered only if no holdover-class alarm appeared during that second.

Start-up and recovery use two different acquire lengths. After warmup, with a clean reference, the controller spends a first acquire period, 600 seconds by default, before it tracks. When the reference comes back after holdover, a longer second acquire period of 1000 seconds by default precedes tracking. Six of the nine alarm flags force holdover. The other three are quality alarms that only drive a minor-alarm output. Each measured phase step larger than a quarter bit raises a correction-in-progress flag. A two-bit status code summarises the state for the management bus.

Top module: `refhold_mode_ctrl`

## Requirements
- R1: After reset, mode is free run (code 0), status is free run (code 2), and avg_vld, corr_flag and avg_phase are 0.
- R2: In free run, mode changes to first acquire (code 1) on a sec_tick only when warm_done is 1 and the window ending at that tick was clean. A window is clean when no hold-class alarm was seen in any cycle of it, including the tick cycle. Mode stays free run while warm_done is 0.
- R3: First acquire lasts ACQ1_SEC ticks counted after entry, then mode becomes tracking (code 2).
- R4: Alarm bits are line_alm[0] loss of signal, [1] loss of frame, [2] AIS, [3] yellow, [4] frequency out of range, [5] jitter above limit, [6] excess bipolar violations, [7] excess CRC-6 errors and [8] excess frame bit errors. Bits set in HOLD_MASK (default bits 0 to 5) are hold-class. Any hold-class bit in tracking or second acquire gives hold (code 3) on the next cycle. In first acquire it gives free run instead.
- R5: Bits 6 to 8 (outside HOLD_MASK) drive minor_alm high while asserted and never change the mode.
- R6: In hold, a clean window at a sec_tick moves mode to second acquire (code 4). Second acquire lasts ACQ2_SEC ticks and then mode becomes tracking.
- R7: At a sec_tick in first acquire, tracking or second acquire, a clean window holding at least one sample gives a one-cycle avg_vld pulse. avg_phase then carries the window's sample sum divided by its sample count, truncated toward zero. A sample strobed in the tick cycle belongs to the closing window.
- R8: A hold-class alarm at any point of a window discards that whole window. No avg_vld is given at its tick, and no exit from hold or free run is taken on it.
- R9: On every samp_stb, corr_flag is set to whether the magnitude of (sample minus previous sample) exceeds QBIT. The previous sample is 0 after reset. corr_flag holds between strobes.
- R10: stat is 3 (failed) whenever osc_fail is 1. Otherwise stat is 0 for first acquire, tracking and second acquire, 1 for hold and 2 for free run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warm_done | input | 1 | Oscillator warmup complete |
| osc_fail | input | 1 | Card hardware failure |
| line_alm | input | 9 | Reference alarm flags, bit map in R4 |
| sec_tick | input | 1 | One-cycle pulse per second |
| samp_stb | input | 1 | Phase sample valid |
| samp_phase | input | PHW | Signed phase error sample |
| mode | output | 3 | Operating mode code |
| avg_vld | output | 1 | Averaged phase valid pulse |
| avg_phase | output | PHW | Signed one-second mean phase |
| corr_flag | output | 1 | Phase step above a quarter bit |
| minor_alm | output | 1 | Non-hold quality alarm present |
| stat | output | 2 | Management status code |

## Verification
A wrong acquire timer shows on mode one tick early or late at the end of either acquire period. A wrong window flag shows at the very next tick, as a stray or missing avg_vld or an exit from hold taken on a dirty window. Accumulator or count errors show in avg_phase at the first pulse after the fault. Because the reference model is compared every cycle, any divergence is reported within one clock of the output that carries it.

// File: rtl/refhold_mode_ctrl.sv
module refhold_mode_ctrl #(
  parameter int ACQ1_SEC = 600,
  parameter int ACQ2_SEC = 1000,
  parameter int PHW = 16,
  parameter int ACCW = 32,
  parameter int CNTW = 16,
  parameter int QBIT = 64,
  parameter logic [8:0] HOLD_MASK = 9'h03F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  warm_done,
  input  logic                  osc_fail,
  input  logic [8:0]            line_alm,
  input  logic                  sec_tick,
  input  logic                  samp_stb,
  input  logic signed [PHW-1:0] samp_phase,
  output logic [2:0]            mode,
  output logic                  avg_vld,
  output logic signed [PHW-1:0] avg_phase,
  output logic                  corr_flag,
  output logic                  minor_alm,
  output logic [1:0]            stat
);
  localparam int TMAX = (ACQ2_SEC > ACQ1_SEC) ? ACQ2_SEC : ACQ1_SEC;
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {FREE = 3'd0, ACQ1 = 3'd1, TRACK = 3'd2, HOLD = 3'd3, ACQ2 = 3'd4} mode_t;

  mode_t st;
  logic [TW-1:0] tmr;
  logic signed [ACCW-1:0] sum_q;
  logic [CNTW-1:0] cnt_q;
  logic win_bad;
  logic signed [PHW-1:0] prev_ph;

  wire hold_c = |(line_alm & HOLD_MASK);
  assign minor_alm = |(line_alm & ~HOLD_MASK);
  wire clean = !win_bad && !hold_c;
  wire active = (st == ACQ1) || (st == TRACK) || (st == ACQ2);

  wire signed [ACCW-1:0] ph_ext = {{(ACCW-PHW){samp_phase[PHW-1]}}, samp_phase};
  wire signed [ACCW-1:0] sum_n = sum_q + (samp_stb ? ph_ext : '0);
  wire [CNTW-1:0] cnt_n = cnt_q + CNTW'(samp_stb);
  wire signed [ACCW-1:0] quo = sum_n / $signed({{(ACCW-CNTW){1'b0}}, cnt_n});

  wire signed [PHW:0] dstep = {samp_phase[PHW-1], samp_phase} - {prev_ph[PHW-1], prev_ph};
  wire signed [PHW:0] dmag = dstep[PHW] ? -dstep : dstep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0; cnt_q <= '0; win_bad <= 1'b0;
      avg_vld <= 1'b0; avg_phase <= '0;
      corr_flag <= 1'b0; prev_ph <= '0;
    end else begin
      if (samp_stb) begin
        corr_flag <= dmag > (PHW+1)'(QBIT);
        prev_ph <= samp_phase;
      end
      avg_vld <= 1'b0;
      if (sec_tick) begin
        if (clean && active && cnt_n != '0) begin
          avg_vld <= 1'b1;
          avg_phase <= quo[PHW-1:0];
        end
        sum_q <= '0; cnt_q <= '0; win_bad <= 1'b0;
      end else begin
        sum_q <= sum_n; cnt_q <= cnt_n; win_bad <= win_bad | hold_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FREE; tmr <= '0;
    end else begin
      case (st)
        FREE: if (sec_tick && clean && warm_done) begin st <= ACQ1; tmr <= '0; end
        ACQ1:
          if (hold_c) st <= FREE;
          else if (sec_tick) begin
            if (tmr == TW'(ACQ1_SEC - 1)) st <= TRACK;
            else tmr <= tmr + 1'b1;
          end
        TRACK: if (hold_c) st <= HOLD;
        HOLD: if (sec_tick && clean) begin st <= ACQ2; tmr <= '0; end
        ACQ2:
          if (hold_c) st <= HOLD;
          else if (sec_tick) begin
            if (tmr == TW'(ACQ2_SEC - 1)) st <= TRACK;
            else tmr <= tmr + 1'b1;
          end
        default: st <= FREE;
      endcase
    end
  end

  assign mode = st;
  assign stat = osc_fail ? 2'd3 :
                (st == HOLD) ? 2'd1 :
                (st == FREE) ? 2'd2 : 2'd0;

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n) mode <= 3'd4);
  a_r4_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd4) && hold_c) |=> mode == 3'd3);
  a_r5_minor_keeps_track: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !hold_c) |=> mode == 3'd2);
  a_r7_vld_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld |-> $past(sec_tick));
  a_r8_fault_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hold_c) |=> !avg_vld);
  a_r2_free_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !warm_done) |=> mode == 3'd0);
  a_r6_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |=> (mode == 3'd3 || mode == 3'd4));
endmodule

// File: tb/refhold_mode_ctrl_tb.sv
`timescale 1ns/1ps
module refhold_mode_ctrl_tb;
  localparam int A1 = 5, A2 = 8, QB = 64, TK = 16;

  logic clk = 0, rst_n = 0, warm_done = 0, osc_fail = 0;
  logic [8:0] line_alm = '0;
  logic sec_tick = 0, samp_stb = 0;
  logic signed [15:0] samp_phase = '0;
  logic [2:0] mode;
  logic avg_vld, corr_flag, minor_alm;
  logic signed [15:0] avg_phase;
  logic [1:0] stat;

  int checks = 0, errors = 0, cyc = 0, amp = 20;
  int corr_seen = 0, vld_seen = 0;

  refhold_mode_ctrl #(.ACQ1_SEC(A1), .ACQ2_SEC(A2), .QBIT(QB)) u_dut (
    .clk(clk), .rst_n(rst_n), .warm_done(warm_done), .osc_fail(osc_fail),
    .line_alm(line_alm), .sec_tick(sec_tick), .samp_stb(samp_stb),
    .samp_phase(samp_phase), .mode(mode), .avg_vld(avg_vld),
    .avg_phase(avg_phase), .corr_flag(corr_flag), .minor_alm(minor_alm),
    .stat(stat));

  always #2.5 clk = ~clk;

  // stimulus generator: tick every TK cycles, sample every 3 cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    sec_tick <= ((cyc + 1) % TK) == 0;
    samp_stb <= ((cyc + 1) % 3) == 0;
    samp_phase <= 16'(((cyc * 37) % (2 * amp + 1)) - amp);
  end

  // behavioural reference model
  int m_mode, m_tmr, m_sum, m_cnt, m_prev, m_avg;
  bit m_bad, m_vld, m_corr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tmr = 0; m_sum = 0; m_cnt = 0; m_prev = 0; m_avg = 0;
      m_bad = 0; m_vld = 0; m_corr = 0;
    end else begin
      bit hc, cl, act;
      int s, c, ph, d;
      ph = samp_phase;
      hc = (line_alm[5:0] != 0);
      cl = !m_bad && !hc;
      act = (m_mode == 1 || m_mode == 2 || m_mode == 4);
      if (samp_stb) begin
        d = ph - m_prev; if (d < 0) d = -d;
        m_corr = d > QB; m_prev = ph;
      end
      s = m_sum + (samp_stb ? ph : 0);
      c = m_cnt + (samp_stb ? 1 : 0);
      m_vld = 0;
      if (sec_tick) begin
        if (cl && act && c > 0) begin m_vld = 1; m_avg = s / c; end
        m_sum = 0; m_cnt = 0; m_bad = 0;
      end else begin
        m_sum = s; m_cnt = c; m_bad = m_bad | hc;
      end
      case (m_mode)
        0: if (sec_tick && cl && warm_done) begin m_mode = 1; m_tmr = 0; end
        1: if (hc) m_mode = 0;
           else if (sec_tick) begin m_tmr++; if (m_tmr == A1) m_mode = 2; end
        2: if (hc) m_mode = 3;
        3: if (sec_tick && cl) begin m_mode = 4; m_tmr = 0; end
        4: if (hc) m_mode = 3;
           else if (sec_tick) begin m_tmr++; if (m_tmr == A2) m_mode = 2; end
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) if (rst_n) begin
    int es;
    es = osc_fail ? 3 : (m_mode == 3) ? 1 : (m_mode == 0) ? 2 : 0;
    chk("R2 R3 R4 R6 mode", mode, m_mode);
    chk("R7 R8 avg_vld", avg_vld, m_vld);
    if (m_vld) chk("R7 avg_phase", avg_phase, m_avg);
    chk("R9 corr_flag", corr_flag, m_corr);
    chk("R5 minor_alm", minor_alm, line_alm[8:6] != 0);
    chk("R10 stat", stat, es);
    if (corr_flag) corr_seen++;
    if (avg_vld) vld_seen++;
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff sec_tick);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 mode", mode, 0); chk("R1 stat", stat, 2);
    chk("R1 avg_vld", avg_vld, 0); chk("R1 corr", corr_flag, 0);
    chk("R1 avg_phase", avg_phase, 0);
    rst_n = 1;
    wait_ticks(3);
    chk("R2 no exit without warmup", mode, 0);
    warm_done = 1;
    wait_ticks(1);
    chk("R2 enter first acquire", mode, 1);
    wait_ticks(A1 - 1);
    chk("R3 still acquiring", mode, 1);
    wait_ticks(1);
    chk("R3 tracking", mode, 2);
    chk("R7 averages delivered", vld_seen > 0, 1);
    line_alm = 9'h1C0;
    wait_ticks(3);
    chk("R5 minor alarm no hold", mode, 2);
    chk("R5 minor_alm", minor_alm, 1);
    line_alm = '0;
    amp = 300;
    wait_ticks(2);
    chk("R9 correction seen", corr_seen > 0, 1);
    amp = 20;
    wait_ticks(1);
    repeat (4) @(negedge clk);
    line_alm = 9'h001;
    @(negedge clk);
    chk("R4 hold on loss of signal", mode, 3);
    chk("R10 hold status", stat, 1);
    line_alm = '0;
    wait_ticks(1);
    chk("R8 dirty window keeps hold", mode, 3);
    wait_ticks(1);
    chk("R6 second acquire", mode, 4);
    wait_ticks(A2 - 1);
    chk("R6 still acquiring", mode, 4);
    wait_ticks(1);
    chk("R6 tracking again", mode, 2);
    osc_fail = 1;
    @(negedge clk);
    chk("R10 failed status", stat, 3);
    osc_fail = 0;
    line_alm = 9'h020;
    @(negedge clk);
    chk("R4 hold on jitter", mode, 3);
    line_alm = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    wait_ticks(2);
    chk("R2 acquire after reset", mode, 1);
    line_alm = 9'h002;
    @(negedge clk);
    chk("R4 fault in first acquire gives free run", mode, 0);
    line_alm = '0;
    wait_ticks(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule